// File: doc/BRIEF.md
# Bus Configuration Register with I/O Width Auto-Detect

This block is an 8-bit configuration register for a bus-master network controller. Software reaches it through a plain register write port and a read bus that always shows the current contents. The register holds two enables that let the DMA engines burst on memory reads and on memory writes, and a 3-bit field that only stores a value. It also holds a sticky flag that selects double-word I/O mode. Software cannot write this flag.

The mode flag has three ways to change. Hardware watches host I/O writes and sets the flag when it sees a full 32-bit write to the data-port offset. A non-volatile load strobe gives the flag its start-up value. A hard reset clears it. Writes to the software bits take effect only while the device reports that it is stopped or suspended. A write at any other time completes normally and changes nothing. The soft reset input and the stop status leave every stored bit as it is. The burst enables and the mode flag are also driven out as level signals for the bus logic and the DMA logic.

Top module: `bus_cfg_reg`

## Requirements
- R1: After a hard reset (`rst_n` low at a clock edge), `cfg_rdata` reads 8'h01. All three level outputs are 0.
- R2: Bits 4 and 3 of `cfg_rdata` always read 0, whatever has been written.
- R3: A write (`cfg_wr` high) made while `stop_st` or `spnd_st` is high loads `cfg_wdata` bit 6 into burst-read enable, bit 5 into burst-write enable, and bits 2:0 into the spare field. These bits read back at the same positions from the next cycle on.
- R4: A write made while `stop_st` and `spnd_st` are both low leaves every bit of `cfg_rdata` unchanged.
- R5: Bit 7 of `cfg_rdata` is the double-word mode flag. A register write never changes it.
- R6: The mode flag becomes 1 on the cycle after `io_wr` is high with `io_be` equal to 4'b1111 and `io_ofs` equal to 5'h10. An I/O write with any other byte-enable pattern or any other offset leaves it at 0.
- R7: Once the mode flag is 1, it stays 1 until a hard reset, or until a `nv_load` pulse with `nv_mode` at 0. A `nv_load` pulse copies `nv_mode` into the flag.
- R8: A `soft_rst` pulse, or a change of `stop_st`, changes no bit of `cfg_rdata`.
- R9: A hard reset wins over a qualifying I/O write in the same cycle. A qualifying I/O write wins over a `nv_load` in the same cycle.
- R10: `burst_rd_en`, `burst_wr_en` and `dword_mode` always equal bits 6, 5 and 7 of `cfg_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst | input | 1 | Soft reset; has no effect on this register |
| stop_st | input | 1 | Device-stopped status |
| spnd_st | input | 1 | Device-suspended status |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Current register contents |
| nv_load | input | 1 | Non-volatile preset load strobe |
| nv_mode | input | 1 | Preset value for the mode flag |
| io_wr | input | 1 | Host I/O write seen on the bus |
| io_ofs | input | 5 | Offset of that I/O write from the I/O base |
| io_be | input | 4 | Byte enables of that I/O write |
| burst_rd_en | output | 1 | Burst-read enable level |
| burst_wr_en | output | 1 | Burst-write enable level |
| dword_mode | output | 1 | Double-word I/O mode level |

## Verification
The bench builds the block with its defaults: a 5-bit I/O offset, 4 byte enables, a data-port offset of 5'h10 and a spare-field reset value of 3'b001. With these values every one of the 512 offset and byte-enable combinations can be tried from a fresh reset, so each near-miss of the width detector is covered. Every one of the 256 write-data values is written under all four combinations of the stop and suspend inputs, and each write's readback is compared with a value worked out in the bench. Directed sequences then cover the sticky clear paths and the same-cycle priority of reset, detection and preset load.

// File: rtl/bcr_pkg.sv
`timescale 1ns/1ps
// Package: shared field positions and the stored-state type of the bus
// configuration register. Bit positions are fixed because software and
// the bus logic decode them.
package bcr_pkg;
    localparam int REG_W    = 8;
    localparam int FLD_W    = 3;
    localparam int POS_MODE = 7;
    localparam int POS_BRD  = 6;
    localparam int POS_BWR  = 5;
    localparam int POS_RSV_HI = 4;
    localparam int POS_RSV_LO = 3;
    localparam int POS_FLD_HI = FLD_W - 1;

    // Software-controlled part of the register.
    typedef struct packed {
        logic             brd;
        logic             bwr;
        logic [FLD_W-1:0] fld;
    } sw_bits_t;
endpackage

// File: rtl/bcr_width_detect.sv
`timescale 1ns/1ps
// Module: bcr_width_detect
// Watches host I/O writes. Raises hit when one write covers all byte lanes
// and targets the data-port offset.
// Assumes: io_* inputs are valid for the one cycle io_wr is high.
module bcr_width_detect #(
    parameter int OFS_W    = 5,
    parameter int BE_W     = 4,
    parameter int PORT_OFS = 16
) (
    input  logic             io_wr,
    input  logic [OFS_W-1:0] io_ofs,
    input  logic [BE_W-1:0]  io_be,
    output logic             hit
);
    localparam logic [OFS_W-1:0] PORT_ADDR = OFS_W'(PORT_OFS);

    logic [BE_W-1:0] lane_on;

    // One flag per byte lane, so the full-width test works for any lane count.
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_on[g] = io_be[g];
    end

    // Qualifying access: a write, all lanes enabled, at the data-port offset.
    always_comb begin
        hit = io_wr && (&lane_on) && (io_ofs == PORT_ADDR);
    end
endmodule

// File: rtl/bcr_write_gate.sv
`timescale 1ns/1ps
// Module: bcr_write_gate
// Lets a software write through only while the device is stopped or
// suspended. A blocked write is dropped and nothing reports it.
// Assumes: the status inputs are synchronous to clk.
module bcr_write_gate (
    input  logic wr_req,
    input  logic stop_st,
    input  logic spnd_st,
    output logic wr_ok
);
    // Pass the write strobe only in a quiescent device state.
    always_comb begin
        wr_ok = wr_req && (stop_st || spnd_st);
    end
endmodule

// File: rtl/bcr_mode_flag.sv
`timescale 1ns/1ps
// Module: bcr_mode_flag
// Sticky double-word mode flag. Priority: hard reset, then detector set,
// then preset load. Nothing else changes the flag.
// Assumes: rst_n is synchronous and active low.
module bcr_mode_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic load_i,
    input  logic load_val,
    output logic mode_q
);
    // Update the flag from reset, detector or preset in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (set_i) begin
            mode_q <= 1'b1;
        end else if (load_i) begin
            mode_q <= load_val;
        end
    end
endmodule

// File: rtl/bcr_sw_bits.sv
`timescale 1ns/1ps
// Module: bcr_sw_bits
// Storage for the software-writable bits: the two burst enables and the
// spare field. Hard reset loads the reset pattern. Soft reset and stop
// status are not inputs here, so they cannot disturb the contents.
// Assumes: wr_ok is already gated by device state.
module bcr_sw_bits
    import bcr_pkg::*;
#(
    parameter logic [FLD_W-1:0] FLD_RST = 3'b001
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_ok,
    input  sw_bits_t wr_val,
    output sw_bits_t cur
);
    // Hold the software bits; load them on a gated write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur.brd <= 1'b0;
            cur.bwr <= 1'b0;
            cur.fld <= FLD_RST;
        end else if (wr_ok) begin
            cur <= wr_val;
        end
    end
endmodule

// File: rtl/bus_cfg_reg.sv
`timescale 1ns/1ps
// Module: bus_cfg_reg
// Bus configuration register with I/O width auto-detect. Combines the
// gated software bits, the sticky mode flag and the width detector, and
// puts together the read view. Reserved bits read as zero.
// Assumes: all inputs are synchronous to clk; rst_n is the hard reset.
module bus_cfg_reg
    import bcr_pkg::*;
#(
    parameter int              OFS_W    = 5,
    parameter int              BE_W     = 4,
    parameter int              PORT_OFS = 16,
    parameter logic [FLD_W-1:0] FLD_RST = 3'b001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stop_st,
    input  logic             spnd_st,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             nv_load,
    input  logic             nv_mode,
    input  logic             io_wr,
    input  logic [OFS_W-1:0] io_ofs,
    input  logic [BE_W-1:0]  io_be,
    output logic             burst_rd_en,
    output logic             burst_wr_en,
    output logic             dword_mode
);
    logic     wr_ok;
    logic     det_hit;
    logic     mode_q;
    sw_bits_t wr_val;
    sw_bits_t sw_q;

    // Pick the writable fields out of the write data.
    always_comb begin
        wr_val.brd = cfg_wdata[POS_BRD];
        wr_val.bwr = cfg_wdata[POS_BWR];
        wr_val.fld = cfg_wdata[POS_FLD_HI:0];
    end

    bcr_write_gate u_gate (
        .wr_req  (cfg_wr),
        .stop_st (stop_st),
        .spnd_st (spnd_st),
        .wr_ok   (wr_ok)
    );

    bcr_width_detect #(
        .OFS_W    (OFS_W),
        .BE_W     (BE_W),
        .PORT_OFS (PORT_OFS)
    ) u_detect (
        .io_wr  (io_wr),
        .io_ofs (io_ofs),
        .io_be  (io_be),
        .hit    (det_hit)
    );

    bcr_mode_flag u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (det_hit),
        .load_i   (nv_load),
        .load_val (nv_mode),
        .mode_q   (mode_q)
    );

    bcr_sw_bits #(
        .FLD_RST (FLD_RST)
    ) u_sw (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ok  (wr_ok),
        .wr_val (wr_val),
        .cur    (sw_q)
    );

    // Put the read view together; the reserved positions read zero.
    always_comb begin
        cfg_rdata                           = '0;
        cfg_rdata[POS_MODE]                 = mode_q;
        cfg_rdata[POS_BRD]                  = sw_q.brd;
        cfg_rdata[POS_BWR]                  = sw_q.bwr;
        cfg_rdata[POS_RSV_HI:POS_RSV_LO]    = 2'b00;
        cfg_rdata[POS_FLD_HI:0]             = sw_q.fld;
    end

    // Drive the level outputs for the DMA and bus logic.
    always_comb begin
        burst_rd_en = sw_q.brd;
        burst_wr_en = sw_q.bwr;
        dword_mode  = mode_q;
    end
endmodule

// File: rtl/bus_cfg_reg_checker.sv
`timescale 1ns/1ps
// Module: bus_cfg_reg_checker
// Property checks for bus_cfg_reg, attached with a bind statement.
// Assumes: the default parameters of the top module.
module bus_cfg_reg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       stop_st,
    input logic       spnd_st,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       nv_load,
    input logic       nv_mode,
    input logic       io_wr,
    input logic [4:0] io_ofs,
    input logic [3:0] io_be,
    input logic       burst_rd_en,
    input logic       burst_wr_en,
    input logic       dword_mode
);
    logic qual_hit;
    logic quiet;

    // Qualifying width write, worked out here on its own.
    always_comb qual_hit = io_wr && (io_be == 4'hF) && (io_ofs == 5'h10);
    // No input that may change state is active.
    always_comb quiet = !cfg_wr && !nv_load && !io_wr;

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[4:3] == 2'b00);

    assert_blocked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !stop_st && !spnd_st && !nv_load && !io_wr) |=> $stable(cfg_rdata));

    assert_open_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (stop_st || spnd_st)) |=>
            (cfg_rdata[6:5] == $past(cfg_wdata[6:5]) && cfg_rdata[2:0] == $past(cfg_wdata[2:0])));

    assert_mode_no_sw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !io_wr && !nv_load) |=> $stable(cfg_rdata[7]));

    assert_mode_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        qual_hit |=> dword_mode);

    assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dword_mode && !(nv_load && !nv_mode)) |=> dword_mode);

    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && quiet) |=> $stable(cfg_rdata));

    assert_reset_wins_R9: assert property (@(posedge clk)
        (!rst_n && qual_hit) |=> !dword_mode);

    assert_levels_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_rd_en == cfg_rdata[6]) && (burst_wr_en == cfg_rdata[5]) && (dword_mode == cfg_rdata[7]));
endmodule

bind bus_cfg_reg bus_cfg_reg_checker u_bus_cfg_reg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .stop_st     (stop_st),
    .spnd_st     (spnd_st),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .nv_load     (nv_load),
    .nv_mode     (nv_mode),
    .io_wr       (io_wr),
    .io_ofs      (io_ofs),
    .io_be       (io_be),
    .burst_rd_en (burst_rd_en),
    .burst_wr_en (burst_wr_en),
    .dword_mode  (dword_mode)
);

// File: tb/bus_cfg_reg_bench.sv
`timescale 1ns/1ps
// Bench: inputs are driven on the falling edge and results are sampled on
// the next falling edge, one rising edge later.
module bus_cfg_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n, soft_rst, stop_st, spnd_st, cfg_wr, nv_load, nv_mode, io_wr;
    logic [7:0] cfg_wdata, cfg_rdata;
    logic [4:0] io_ofs;
    logic [3:0] io_be;
    logic       burst_rd_en, burst_wr_en, dword_mode;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;
    logic [7:0] exp_reg;

    always #2.5 clk = ~clk;

    bus_cfg_reg u_bus_cfg_reg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_st(stop_st),
        .spnd_st(spnd_st), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .nv_load(nv_load), .nv_mode(nv_mode),
        .io_wr(io_wr), .io_ofs(io_ofs), .io_be(io_be),
        .burst_rd_en(burst_rd_en), .burst_wr_en(burst_wr_en), .dword_mode(dword_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rst_n = 1'b1; soft_rst = 1'b0; stop_st = 1'b0; spnd_st = 1'b0;
        cfg_wr = 1'b0; cfg_wdata = '0; nv_load = 1'b0; nv_mode = 1'b0;
        io_wr = 1'b0; io_ofs = '0; io_be = '0;
    endtask

    // Let one rising edge act on the present inputs, then return to idle.
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic hard_reset();
        idle(); rst_n = 1'b0;
        tick();
    endtask

    task automatic chk_levels(input string req);
        chk(req, {5'd0, burst_rd_en, burst_wr_en, dword_mode},
            {5'd0, cfg_rdata[6], cfg_rdata[5], cfg_rdata[7]});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        idle();
        @(negedge clk);
        hard_reset(); hard_reset();
        // R1: reset values.
        chk("R1 reset value", cfg_rdata, 8'h01);
        chk("R1 level outputs", {5'd0, burst_rd_en, burst_wr_en, dword_mode}, 8'h00);

        // R3/R4/R2/R5: every data value under every stop/suspend mix.
        exp_reg = 8'h01;
        for (int g = 0; g < 4; g++) begin
            for (int d = 0; d < 256; d++) begin
                stop_st = g[0]; spnd_st = g[1]; cfg_wr = 1'b1; cfg_wdata = 8'(d);
                tick();
                if (g != 0) exp_reg = {exp_reg[7], cfg_wdata_bits(d)};
                chk(g != 0 ? "R3 gated write" : "R4 blocked write", cfg_rdata, exp_reg);
                if (d == 8'hFF) begin
                    chk("R2 reserved zero", {6'd0, cfg_rdata[4:3]}, 8'h00);
                    chk_levels("R10 levels after write");
                end
            end
        end

        // R6: every offset and byte-enable pattern from a fresh reset.
        for (int o = 0; o < 32; o++) begin
            for (int b = 0; b < 16; b++) begin
                hard_reset();
                io_wr = 1'b1; io_ofs = 5'(o); io_be = 4'(b);
                tick();
                chk("R6 width detect", {7'd0, dword_mode}, {7'd0, (o == 16 && b == 15)});
            end
        end
        // R6: right offset and width without the write strobe.
        hard_reset();
        io_ofs = 5'h10; io_be = 4'hF;
        tick();
        chk("R6 no strobe", {7'd0, dword_mode}, 8'h00);

        // R5/R7/R8: sticky behaviour once set.
        hard_reset();
        stop_st = 1'b1; cfg_wr = 1'b1; cfg_wdata = 8'h65;
        tick();
        io_wr = 1'b1; io_ofs = 5'h10; io_be = 4'hF;
        tick();
        chk("R6 set keeps sw bits", cfg_rdata, 8'hE5);
        chk_levels("R10 levels with mode set");
        soft_rst = 1'b1;
        tick();
        chk("R8 soft reset no effect", cfg_rdata, 8'hE5);
        stop_st = 1'b1;
        tick();
        chk("R8 stop no effect", cfg_rdata, 8'hE5);
        stop_st = 1'b1; cfg_wr = 1'b1; cfg_wdata = 8'h00;
        tick();
        chk("R5 mode ignores write", cfg_rdata, 8'h80);
        nv_load = 1'b1; nv_mode = 1'b1;
        tick();
        chk("R7 load of 1 keeps mode", cfg_rdata, 8'h80);
        nv_load = 1'b1; nv_mode = 1'b0;
        tick();
        chk("R7 load of 0 clears mode", cfg_rdata, 8'h00);
        nv_load = 1'b1; nv_mode = 1'b1;
        tick();
        chk("R7 preset sets mode", cfg_rdata, 8'h80);
        hard_reset();
        chk("R7 hard reset clears mode", cfg_rdata, 8'h01);

        // R9: same-cycle priorities.
        rst_n = 1'b0; io_wr = 1'b1; io_ofs = 5'h10; io_be = 4'hF;
        tick();
        chk("R9 reset beats detect", cfg_rdata, 8'h01);
        io_wr = 1'b1; io_ofs = 5'h10; io_be = 4'hF; nv_load = 1'b1; nv_mode = 1'b0;
        tick();
        chk("R9 detect beats load", cfg_rdata, 8'h81);

        done = 1'b1;
        finish_run();
    end

    // Expected low seven bits after an accepted write of d (R2, R3).
    function automatic logic [6:0] cfg_wdata_bits(input int d);
        logic [7:0] v;
        v = 8'(d);
        return {v[6], v[5], 2'b00, v[2:0]};
    endfunction
endmodule